// File: doc/BRIEF.md
# Serial Frame Transmitter with Selectable Bit Clock

This block sends whole serial frames on a data line (`txd_o`). It can also drive a companion bit clock (`txc_o`). Each frame word comes from a show-ahead transmit FIFO and already holds every line bit in place: start, data, parity and stop. The word is sent least significant bit first. The frame length is a 5-bit setting, from 1 to 31 line bits. A length of zero keeps the transmitter idle.

Timing comes from an external strobe, `bit_tick_i`, which marks half bit periods. A rate generator that divides the system clock by (divisor + 1) is expected to run it at twice the wanted bit rate. Each bit lasts two half periods: a lead half and a trail half. In the clocked modes, `txc_o` takes its "data changes here" edge at the start of the lead half and turns back at the start of the trail half. A 3-bit clock mode picks between a constant-0 output, a constant-1 output, and four clocked variants. The variants differ in idle level and in which edge carries the data change. The frame length and the clock mode are captured when a frame starts.

The controller is a three-state machine:
- ST_IDLE holds the line high and the clock at its idle level. When the FIFO is not empty and the length is non-zero, it pops a word (transition IDLE→LEAD).
- ST_LEAD moves to ST_TRAIL on a strobe (LEAD→TRAIL).
- ST_TRAIL, on a strobe, does one of three things:
  - advances to the next bit (TRAIL→LEAD);
  - on the last bit, fetches the next word at once (TRAIL→LEAD with a pop);
  - on the last bit with an empty FIFO, returns to idle (TRAIL→IDLE).

Top module: `serial_frame_tx`

## Requirements
- R1: While reset is held and in the first cycle after release with an empty FIFO, `txd_o` is 1, `fifo_pop_o` is 0, and `txc_o` shows the idle level of the current mode.
- R2: `fifo_pop_o` is asserted only while `fifo_empty_i` is 0, for exactly one cycle per frame. The word on `fifo_data_i` in that cycle is the one transmitted.
- R3: Word bit k is driven on `txd_o` for the whole of line bit k, counting from bit 0. Each line bit spans exactly two strobe-delimited half periods, and the first half begins in the cycle after the pop.
- R4: A frame carries exactly `frame_len_i` line bits. Afterwards, with an empty FIFO, `txd_o` returns to 1.
- R5: If the FIFO holds a word when the last half period of a frame ends, that word is popped in that same cycle. Its bit 0 follows with no idle gap.
- R6: With a frame length of 0, no word is popped and `txd_o` stays 1.
- R7: Clock modes 000, 010 and 011 hold `txc_o` at 0, and mode 001 holds it at 1, both during frames and in idle.
- R8: Mode 100: `txc_o` idles at 0. It is 1 in the lead half and 0 in the trail half, so data changes on its rising edge.
- R9: Mode 101: `txc_o` idles at 1. It is 0 in the lead half and 1 in the trail half, so data changes on its falling edge.
- R10: Mode 110 idles at 0 with lead 0 and trail 1, so data changes on falling edges. Mode 111 idles at 1 with lead 1 and trail 0, so data changes on rising edges.
- R11: `txd_o` and `txc_o` change only in the cycle after a strobe or a pop, or in idle after a mode change.
- R12: Changes to `frame_len_i` or `txc_mode_i` during a frame do not alter that frame. The idle clock level follows the live mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick_i | input | 1 | Half-bit-period strobe, one cycle wide |
| frame_len_i | input | 5 | Line bits per frame; 0 disables sending |
| txc_mode_i | input | 3 | Bit clock mode select |
| fifo_empty_i | input | 1 | Transmit FIFO has no word |
| fifo_data_i | input | 32 | Head word of the FIFO (show-ahead) |
| fifo_pop_o | output | 1 | Consume the head word this cycle |
| txd_o | output | 1 | Serial data line |
| txc_o | output | 1 | Companion bit clock |

## Verification
A bad bit count or shift register changes the line pattern of the frame. Such a fault shows up on `txd_o` or `txc_o` within one half period of the slip: an early idle level, an extra bit, or a misplaced data bit. A state machine stuck in the wrong half inverts `txc_o` for the following half period in every clocked mode. A missed back-to-back fetch inserts idle ones where a start bit of 0 was expected. The scoreboard compares both lines in every cycle of every frame, so any such fault is caught in the first cycle it appears.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } tx_state_e;

    // level of the bit clock while no frame is active
    function automatic logic clk_idle_level(input logic [2:0] mode);
        if (mode[2])
            return mode[0];
        return (mode == 3'b001);
    endfunction

    // level of the bit clock during the lead half of each bit
    function automatic logic clk_lead_level(input logic [2:0] mode);
        if (mode[2])
            return ~(mode[1] ^ mode[0]);
        return (mode == 3'b001);
    endfunction

endpackage

// File: rtl/txs_bit_counter.sv
module txs_bit_counter #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             step_i,
    output logic             last_o
);
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= len_i;
        else if (step_i)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last_o = (cnt_q == LEN_W'(1));

    // R4: never step a counter that has no bits left
    a_r4_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (cnt_q != '0));

endmodule

// File: rtl/txs_shifter.sv
module txs_shifter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              shift_i,
    output logic              bit_o
);
    logic [DATA_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '1;
        else if (load_i)
            sh_q <= word_i;
        else if (shift_i)
            sh_q <= {1'b1, sh_q[DATA_W-1:1]};
    end

    assign bit_o = sh_q[0];

endmodule

// File: rtl/txs_clk_shaper.sv
module txs_clk_shaper
    import tx_ser_pkg::*;
(
    input  tx_state_e  state_i,
    input  logic [2:0] run_mode_i,
    input  logic [2:0] live_mode_i,
    output logic       txc_o
);
    always_comb begin
        unique case (state_i)
            ST_LEAD:  txc_o = clk_lead_level(run_mode_i);
            ST_TRAIL: txc_o = run_mode_i[2] ? ~clk_lead_level(run_mode_i)
                                            : clk_lead_level(run_mode_i);
            default:  txc_o = clk_idle_level(live_mode_i);
        endcase
    end

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import tx_ser_pkg::*;
#(
    parameter int LEN_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick_i,
    input  logic [LEN_W-1:0]  frame_len_i,
    input  logic [2:0]        txc_mode_i,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] fifo_data_i,
    output logic              fifo_pop_o,
    output logic              txd_o,
    output logic              txc_o
);
    localparam int MAX_BITS = (1 << LEN_W) - 1;

    tx_state_e  state_q, state_d;
    logic [2:0] mode_q;
    logic       can_start, last_bit;
    logic       load, shift, line_bit;

    assign can_start = !fifo_empty_i && (frame_len_i != '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // clock mode captured at frame start
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 3'b000;
        else if (load)
            mode_q <= txc_mode_i;
    end

    // next state and control strobes
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        shift   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (can_start) begin
                    load    = 1'b1;
                    state_d = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (bit_tick_i)
                    state_d = ST_TRAIL;
            end
            ST_TRAIL: begin
                if (bit_tick_i) begin
                    if (!last_bit) begin
                        shift   = 1'b1;
                        state_d = ST_LEAD;
                    end else if (can_start) begin
                        load    = 1'b1;
                        state_d = ST_LEAD;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    txs_bit_counter #(.LEN_W(LEN_W)) i_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .len_i  (frame_len_i),
        .step_i (shift),
        .last_o (last_bit)
    );

    txs_shifter #(.DATA_W(DATA_W)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .word_i  (fifo_data_i),
        .shift_i (shift),
        .bit_o   (line_bit)
    );

    txs_clk_shaper i_clk (
        .state_i     (state_q),
        .run_mode_i  (mode_q),
        .live_mode_i (txc_mode_i),
        .txc_o       (txc_o)
    );

    // outputs
    always_comb begin
        fifo_pop_o = load;
        unique case (state_q)
            ST_LEAD, ST_TRAIL: txd_o = line_bit;
            default:           txd_o = 1'b1;
        endcase
    end

    initial begin
        assert (DATA_W >= MAX_BITS) else $error("word narrower than longest frame");
    end

    // R2: never consume from an empty FIFO
    a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |-> !fifo_empty_i);

    // R4: idle line is high
    a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> txd_o);

    // R5: last bit ends with a waiting word -> next frame starts at once
    a_r5_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAIL && bit_tick_i && last_bit && !fifo_empty_i
         && frame_len_i != '0) |=> (state_q == ST_LEAD));

    // R6: zero length never pops
    a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_len_i == '0) |-> !fifo_pop_o);

    // R11: outputs move only after a strobe, a pop or a live mode change
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bit_tick_i) && !$past(fifo_pop_o) && $stable(txc_mode_i))
        |-> ($stable(txd_o) && $stable(txc_o)));

    // R12: captured mode holds for the whole frame
    a_r12_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !fifo_pop_o) |=> $stable(mode_q));

endmodule

// File: tb/test_serial_frame_tx.sv
module test_serial_frame_tx;

    typedef struct packed {
        logic txd;
        logic txc;
    } half_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick_i = 1'b0;
    logic [4:0]  frame_len_i = 5'd8;
    logic [2:0]  txc_mode_i = 3'b100;
    logic        fifo_empty_i = 1'b1;
    logic [31:0] fifo_data_i = '0;
    logic        fifo_pop_o, txd_o, txc_o;

    int total = 0;
    int bad = 0;
    int armed = 0;
    int mon_len = 8;
    string mon_tag = "R3";
    logic [31:0] fq[$];
    half_t exq[$];

    serial_frame_tx i_serial_frame_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick_i   (bit_tick_i),
        .frame_len_i  (frame_len_i),
        .txc_mode_i   (txc_mode_i),
        .fifo_empty_i (fifo_empty_i),
        .fifo_data_i  (fifo_data_i),
        .fifo_pop_o   (fifo_pop_o),
        .txd_o        (txd_o),
        .txc_o        (txc_o)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void refresh();
        fifo_empty_i = (fq.size() == 0);
        fifo_data_i  = (fq.size() != 0) ? fq[0] : 32'h0;
    endfunction

    function automatic logic idle_lvl(input logic [2:0] m);
        return m[2] ? m[0] : (m == 3'b001);
    endfunction

    function automatic logic lead_lvl(input logic [2:0] m);
        return m[2] ? ~(m[1] ^ m[0]) : (m == 3'b001);
    endfunction

    // half-bit strobe: every 4th cycle
    initial begin
        int cnt = 0;
        forever begin
            @(posedge clk); #2;
            cnt = (cnt == 3) ? 0 : cnt + 1;
            bit_tick_i = (cnt == 3);
        end
    end

    // monitor / scoreboard and FIFO model
    initial begin
        bit pend;
        forever begin
            @(negedge clk);
            pend = 1'b0;
            if (rst_n) begin
                if (armed > 0) begin
                    if (exq.size() == 0) begin
                        check(0, mon_tag, 0, 1);
                        armed = 0;
                    end else begin
                        check(txd_o == exq[0].txd, {mon_tag, " txd"}, int'(txd_o), int'(exq[0].txd));
                        check(txc_o == exq[0].txc, {mon_tag, " txc"}, int'(txc_o), int'(exq[0].txc));
                        if (bit_tick_i) begin
                            void'(exq.pop_front());
                            armed--;
                        end
                    end
                end
                if (fifo_pop_o) begin
                    // R2: pop only with a word waiting
                    check(fq.size() != 0, "R2 pop on empty", 1, 0);
                    pend = 1'b1;
                    armed += 2 * mon_len;
                end
            end
            @(posedge clk); #1;
            if (pend && fq.size() != 0) begin
                void'(fq.pop_front());
                refresh();
            end
        end
    end

    task automatic send(input int n, input logic [31:0] seed, input int len,
                        input logic [2:0] mode, input string tag);
        @(posedge clk); #3;
        frame_len_i = 5'(len);
        txc_mode_i  = mode;
        mon_len     = len;
        mon_tag     = tag;
        for (int k = 0; k < n; k++) begin
            logic [31:0] w;
            w = (seed * 32'h9E37_79B1 + 32'(k) * 32'h0101_3573) & 32'hFFFF_FFFE;
            for (int b = 0; b < len; b++) begin
                half_t h;
                h.txd = w[b];
                h.txc = lead_lvl(mode);
                exq.push_back(h);
                h.txc = mode[2] ? ~lead_lvl(mode) : lead_lvl(mode);
                exq.push_back(h);
            end
            fq.push_back(w);
        end
        refresh();
    endtask

    task automatic wait_done(input string tag);
        int guard = 0;
        while ((fq.size() != 0 || armed != 0) && guard < 20000) begin
            @(posedge clk);
            guard++;
        end
        check(guard < 20000, {tag, " completion"}, guard, 0);
        check(exq.size() == 0, {tag, " leftover halves"}, exq.size(), 0);
        @(negedge clk);
        check(txd_o == 1'b1, {tag, " idle txd"}, int'(txd_o), 1);
        check(txc_o == idle_lvl(txc_mode_i), {tag, " idle txc"}, int'(txc_o), int'(idle_lvl(txc_mode_i)));
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(txd_o == 1'b1, "R1 txd in reset", int'(txd_o), 1);
        check(fifo_pop_o == 1'b0, "R1 pop in reset", int'(fifo_pop_o), 0);
        check(txc_o == 1'b0, "R1 txc in reset", int'(txc_o), 0);
        @(posedge clk); #3;
        rst_n = 1'b1;
        @(negedge clk);
        check(txd_o == 1'b1 && txc_o == 1'b0 && !fifo_pop_o, "R1 after release",
              int'({txd_o, txc_o, fifo_pop_o}), 4);

        // R8 with R3 R4 R5: three back-to-back frames
        send(3, 32'h11, 10, 3'b100, "R8_R3_R5");
        wait_done("R4");

        send(1, 32'h22, 8, 3'b101, "R9");
        wait_done("R9");

        send(2, 32'h33, 5, 3'b110, "R10 mode110");
        wait_done("R10 mode110");

        send(1, 32'h44, 31, 3'b111, "R10 mode111 len31");
        wait_done("R10 mode111");

        // R7: constant clock modes, and single-bit frames
        send(2, 32'h55, 4, 3'b000, "R7 mode000");
        wait_done("R7 mode000");
        send(2, 32'h66, 4, 3'b001, "R7 mode001");
        wait_done("R7 mode001");
        send(2, 32'h77, 1, 3'b010, "R7 mode010 len1");
        wait_done("R7 mode010");
        send(1, 32'h88, 3, 3'b011, "R7 mode011");
        wait_done("R7 mode011");

        // R6: zero length keeps the word in the FIFO
        @(posedge clk); #3;
        frame_len_i = 5'd0;
        txc_mode_i  = 3'b100;
        fq.push_back(32'h0000_00F0);
        refresh();
        repeat (40) begin
            @(negedge clk);
            if (fifo_pop_o || txd_o != 1'b1)
                check(0, "R6 zero length activity", int'({fifo_pop_o, txd_o}), 1);
        end
        check(fq.size() == 1, "R6 word kept", fq.size(), 1);
        @(posedge clk); #3;
        fq.delete();
        refresh();

        // R12: mid-frame setting changes do not touch the frame
        send(1, 32'h99, 6, 3'b100, "R12 frame");
        repeat (10) @(posedge clk);
        #3;
        frame_len_i = 5'd3;
        txc_mode_i  = 3'b101;
        wait_done("R12");
        check(txc_o == 1'b1, "R12 idle follows live mode", int'(txc_o), 1);

        // R11: live mode change in idle moves the clock level
        @(posedge clk); #3;
        txc_mode_i = 3'b001;
        @(negedge clk);
        check(txc_o == 1'b1 && txd_o == 1'b1, "R11 idle mode change", int'({txc_o, txd_o}), 3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule